// File: doc/BRIEF.md
# Supply Power-Up Sequencing Controller

This block brings up a board's local supplies in a fixed order and then watches them. It reads four comparator results. Each one is high while its rail sits above its trip point. It drives three regulator enables and a power-good flag. Every input passes through a two-flop synchronizer. Each input condition must then hold without a break for a programmable number of clock ticks before the controller acts on it. A short spike on a comparator therefore never moves the sequence.

During bring-up each enable follows its own confirmation rail. Once the main rail qualifies, the first enable rises. The rail that enable switches on is confirmed by the next comparator, which releases the next enable, and so on. When all four rails have held together for the long window, power-good rises and the controller starts monitoring. In that mode a sustained loss of the main rail drops every output at once. A sustained loss of any other rail only drops power-good, and the sequence then waits for all rails to requalify.

The long and short windows are tick-count parameters. Their default values give 190 ms and 30 µs at 125 MHz.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, `reg_en` is 3'b000 and `pwr_good` is 0.
- R2: From the idle state, `reg_en` becomes 3'b001 once `rail_ok[0]` has stayed high for LONG_TICKS consecutive cycles.
- R3: With `reg_en`=3'b001, it becomes 3'b011 once `rail_ok[0]` and `rail_ok[1]` have both stayed high for SHORT_TICKS consecutive cycles. The count starts no earlier than the cycle in which the state was entered.
- R4: With `reg_en`=3'b011, it becomes 3'b111 once `rail_ok[0]` and `rail_ok[2]` have both stayed high for SHORT_TICKS consecutive cycles.
- R5: With `reg_en`=3'b111 and `pwr_good`=0, `pwr_good` rises once all four `rail_ok` bits have stayed high together for LONG_TICKS consecutive cycles. `pwr_good` is never high unless `reg_en` is 3'b111.
- R6: With `pwr_good`=1, if any of `rail_ok[3:1]` is low for SHORT_TICKS consecutive cycles, `pwr_good` drops and `reg_en` stays 3'b111.
- R7: In any state other than idle, if `rail_ok[0]` is low for SHORT_TICKS consecutive cycles, `reg_en` and `pwr_good` all go low on the same edge.
- R8: A condition that breaks before its window completes restarts its count from zero. An input pulse one cycle shorter than the window causes no output change.
- R9: An output change occurs on the clock edge exactly window+2 edges after the input change that qualifies it (two synchronizer stages, then the window).
- R10: With `pwr_good`=1, the individual levels of `rail_ok[3:1]` have no effect on `reg_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rail_ok | input | 4 | Comparator results; bit 0 is the main rail, bit n confirms the rail of enable n-1 |
| reg_en | output | 3 | Regulator enables, active high; bit 0 is switched on first |
| pwr_good | output | 1 | All rails up and stable |

## Verification
The bench probes the exact edge of every transition: the output is still unchanged one edge before window+2 and changed on that edge. A filter that is off by one cycle, or that skips a synchronizer stage, is caught there. Pulses one cycle shorter than the window are applied in the idle state and in power-good mode. A timer that does not restart on a gap would fire on these pulses and start the sequence, or drop power-good, too early. The two fault paths are driven separately. A design that swaps them would shut every enable off on a secondary fault, or leave the enables on after the main rail is lost. A timer that is not cleared on a state change would advance the step right after re-entry, before its window has run.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  localparam int NUM_RAILS = 4;
  localparam int NUM_EN    = 3;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ONE   = 3'd1,
    ST_TWO   = 3'd2,
    ST_THREE = 3'd3,
    ST_GOOD  = 3'd4
  } seq_state_t;

  // Enable pattern (thermometer code) for each state
  function automatic logic [NUM_EN-1:0] en_of(seq_state_t s);
    case (s)
      ST_ONE:   return 3'b001;
      ST_TWO:   return 3'b011;
      ST_THREE: return 3'b111;
      ST_GOOD:  return 3'b111;
      default:  return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        stage_q[g] <= '0;
      end else if (g == 0) begin
        stage_q[g] <= din;
      end else begin
        stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/pwr_seq_qual.sv
module pwr_seq_qual #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             cond,
  input  logic [CNT_W-1:0] limit,
  output logic             hit
);

  logic [CNT_W-1:0] cnt_q;

  // hit on the cycle in which cond has been true for `limit` cycles in a row
  assign hit = cond && (cnt_q == limit - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || clear || !cond) begin
      cnt_q <= '0;
    end else if (!hit) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (rst)
    (!cond || clear) |=> (cnt_q == '0)); // R8

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (limit != '0) |-> (cnt_q < limit)); // R8

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int LONG_TICKS  = 23_750_000,
  parameter int SHORT_TICKS = 3_750,
  localparam int CNT_W      = $clog2(LONG_TICKS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_RAILS-1:0] rails,
  output logic [NUM_EN-1:0]    en,
  output logic                 good
);

  localparam logic [CNT_W-1:0] LIM_LONG  = CNT_W'(LONG_TICKS);
  localparam logic [CNT_W-1:0] LIM_SHORT = CNT_W'(SHORT_TICKS);

  seq_state_t state_q, state_nx;
  logic       adv_cond, adv_long, adv_hit;
  logic       main_cond, main_hit;
  logic       sec_cond, sec_hit;
  logic       state_chg;
  logic [CNT_W-1:0] adv_limit;

  // Condition that moves the sequence one step forward
  always_comb begin
    adv_cond = 1'b0;
    adv_long = 1'b0;
    case (state_q)
      ST_IDLE:  begin adv_cond = rails[0];             adv_long = 1'b1; end
      ST_ONE:   adv_cond = rails[0] & rails[1];
      ST_TWO:   adv_cond = rails[0] & rails[2];
      ST_THREE: begin adv_cond = &rails;               adv_long = 1'b1; end
      default:  adv_cond = 1'b0;
    endcase
  end

  assign adv_limit = adv_long ? LIM_LONG : LIM_SHORT;
  assign main_cond = (state_q != ST_IDLE) && !rails[0];
  assign sec_cond  = (state_q == ST_GOOD) && !(&rails[NUM_RAILS-1:1]);

  pwr_seq_qual #(.CNT_W(CNT_W)) u_adv (
    .clk(clk), .rst(rst), .clear(state_chg),
    .cond(adv_cond), .limit(adv_limit), .hit(adv_hit)
  );

  pwr_seq_qual #(.CNT_W(CNT_W)) u_main (
    .clk(clk), .rst(rst), .clear(state_chg),
    .cond(main_cond), .limit(LIM_SHORT), .hit(main_hit)
  );

  pwr_seq_qual #(.CNT_W(CNT_W)) u_sec (
    .clk(clk), .rst(rst), .clear(state_chg),
    .cond(sec_cond), .limit(LIM_SHORT), .hit(sec_hit)
  );

  always_comb begin
    state_nx = state_q;
    case (state_q)
      ST_IDLE:  if (adv_hit) state_nx = ST_ONE;
      ST_ONE:   if (main_hit) state_nx = ST_IDLE; else if (adv_hit) state_nx = ST_TWO;
      ST_TWO:   if (main_hit) state_nx = ST_IDLE; else if (adv_hit) state_nx = ST_THREE;
      ST_THREE: if (main_hit) state_nx = ST_IDLE; else if (adv_hit) state_nx = ST_GOOD;
      ST_GOOD:  if (main_hit) state_nx = ST_IDLE; else if (sec_hit) state_nx = ST_THREE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  assign state_chg = (state_nx != state_q);

  // Outputs decoded from the next state so they switch on the same edge
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      en      <= '0;
      good    <= 1'b0;
    end else begin
      state_q <= state_nx;
      en      <= en_of(state_nx);
      good    <= (state_nx == ST_GOOD);
    end
  end

  AST_GOOD_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    good |-> (en == 3'b111)); // R5

  AST_GOOD_FROM_THREE: assert property (@(posedge clk) disable iff (rst)
    $rose(good) |-> ($past(state_q) == ST_THREE)); // R5

  AST_FIRST_EN_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(en[0]) |-> ($past(state_q) == ST_IDLE && $past(en) == 3'b000)); // R2

  AST_MAIN_DROP_ALL: assert property (@(posedge clk) disable iff (rst)
    $fell(en[0]) |-> (en == 3'b000 && !good)); // R7

  AST_SEC_KEEPS_EN: assert property (@(posedge clk) disable iff (rst)
    ($fell(good) && rails[0] && $past(rails[0])) |-> (en == 3'b111)); // R6

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
  parameter int LONG_TICKS  = 23_750_000,
  parameter int SHORT_TICKS = 3_750,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] rail_ok,
  output logic [2:0] reg_en,
  output logic       pwr_good
);

  logic [3:0] rails_s;

  pwr_seq_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(rail_ok), .dout(rails_s)
  );

  pwr_seq_fsm #(.LONG_TICKS(LONG_TICKS), .SHORT_TICKS(SHORT_TICKS)) u_fsm (
    .clk(clk), .rst(rst), .rails(rails_s), .en(reg_en), .good(pwr_good)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (reg_en == 3'b000 && !pwr_good)); // R1

endmodule

// File: tb/sim_pwr_seq_ctrl.sv
module sim_pwr_seq_ctrl;

  localparam int LONG  = 40;
  localparam int SHORT = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] rail_ok = 4'b0000;
  logic [2:0] reg_en;
  logic       pwr_good;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwr_seq_ctrl #(.LONG_TICKS(LONG), .SHORT_TICKS(SHORT)) u0 (
    .clk(clk), .rst(rst), .rail_ok(rail_ok), .reg_en(reg_en), .pwr_good(pwr_good)
  );

  task automatic check(string req, logic [2:0] exp_en, logic exp_pg);
    checks++;
    if (reg_en !== exp_en || pwr_good !== exp_pg) begin
      errors++;
      $display("FAIL %s: en=%b pg=%b expected en=%b pg=%b", req, reg_en, pwr_good, exp_en, exp_pg);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Drive at negedge, then expect change exactly at edge win+2 (R9)
  task automatic drive_expect(logic [3:0] val, int win, string req,
                              logic [2:0] old_en, logic old_pg,
                              logic [2:0] new_en, logic new_pg);
    @(negedge clk);
    rail_ok = val;
    edges(win + 1);
    check({req, " R9 before"}, old_en, old_pg);
    edges(1);
    check(req, new_en, new_pg);
  endtask

  task automatic pulse(logic [3:0] val, logic [3:0] back, int cyc);
    @(negedge clk);
    rail_ok = val;
    repeat (cyc) @(negedge clk);
    rail_ok = back;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    rail_ok = 4'b0000;
    edges(3);
    check("R1 in reset", 3'b000, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    edges(1);
    check("R1 after reset", 3'b000, 1'b0);
  endtask

  task automatic t_idle_glitch;
    pulse(4'b0001, 4'b0000, LONG - 1);
    edges(LONG + 4);
    check("R8 short main pulse in idle", 3'b000, 1'b0);
  endtask

  task automatic t_powerup;
    drive_expect(4'b0001, LONG,  "R2", 3'b000, 1'b0, 3'b001, 1'b0);
    drive_expect(4'b0011, SHORT, "R3", 3'b001, 1'b0, 3'b011, 1'b0);
    drive_expect(4'b0111, SHORT, "R4", 3'b011, 1'b0, 3'b111, 1'b0);
    drive_expect(4'b1111, LONG,  "R5", 3'b111, 1'b0, 3'b111, 1'b1);
  endtask

  task automatic t_sec_fault;
    pulse(4'b1011, 4'b1111, SHORT - 1);
    edges(SHORT + 4);
    check("R8 short secondary pulse in power-good", 3'b111, 1'b1);
    drive_expect(4'b1101, SHORT, "R6 secondary fault", 3'b111, 1'b1, 3'b111, 1'b0);
    edges(SHORT + 4);
    check("R10 enables held after secondary fault", 3'b111, 1'b0);
    drive_expect(4'b1111, LONG, "R5 requalify", 3'b111, 1'b0, 3'b111, 1'b1);
    @(negedge clk);
    rail_ok = 4'b0001;
    edges(SHORT + 1);
    check("R10 first edge of rail drop", 3'b111, 1'b1);
  endtask

  task automatic t_main_fault_good;
    // from the state left by t_sec_fault (power-good dropping to step three)
    @(negedge clk);
    rail_ok = 4'b1111;
    edges(LONG + 4);
    check("R5 back to power-good", 3'b111, 1'b1);
    drive_expect(4'b1110, SHORT, "R7 main fault in power-good", 3'b111, 1'b1, 3'b000, 1'b0);
  endtask

  task automatic t_reentry_and_mid_fault;
    drive_expect(4'b1111, LONG, "R2 re-entry", 3'b000, 1'b0, 3'b001, 1'b0);
    edges(SHORT - 1);
    check("R3 timer cleared on entry", 3'b001, 1'b0);
    edges(1);
    check("R3 advance after full window", 3'b011, 1'b0);
    drive_expect(4'b1110, SHORT, "R7 main fault mid-sequence", 3'b011, 1'b0, 3'b000, 1'b0);
  endtask

  initial begin
    t_reset();
    t_idle_glitch();
    t_powerup();
    t_sec_fault();
    t_main_fault_good();
    t_reentry_and_mid_fault();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule